// File: doc/BRIEF.md
# Bank-Switched Upper Memory Mapper

This block steers every CPU access to the top 12K of a 64K, 8-bit address space, from $D000 to $FFFF. For each request it decides whether the access goes to ROM, goes to RAM, or is dropped. When the access goes to RAM, the block also produces the translated RAM address. The RAM behind the window is 16K in size, so the lowest 4K page of the window can be backed by either of two RAM pages.

Three mode bits, held in a small register, set the routing:

- **RAM-read** selects whether reads are served by RAM or by ROM.
- **RAM-write** selects whether writes reach RAM or are discarded.
- **Bank-2** selects which RAM page backs $D000-$DFFF.

Read routing and write routing are independent. Software can therefore fill RAM while it still executes from ROM. The mode bits are loaded through a direct control port. The data paths of the memories are outside the block.

Top module: `upper_mem_mapper`

## Requirements
- R1: Reset (rst_ni low) clears all three mode bits. After reset, a read at $E000 asserts rom_re_o only, and a write there asserts no output.
- R2: When RAM-write is 0, a write in the window asserts none of rom_re_o, ram_re_o or ram_we_o.
- R3: When RAM-write is 1, a write in the window asserts ram_we_o only, and ram_addr_o carries the translated address.
- R4: A read in the window asserts ram_re_o if RAM-read is 1, and rom_re_o otherwise. The RAM-write bit does not affect reads, and rom_re_o is never high together with a RAM enable.
- R5: An access at $E000-$FFFF that reaches RAM uses ram_addr_o equal to req_addr_i.
- R6: An access at $D000-$DFFF that reaches RAM uses ram_addr_o with bits [15:12] equal to 4'hD when Bank-2 is 1, and 4'hC when Bank-2 is 0. Bits [11:0] equal those of req_addr_i.
- R7: A request with req_addr_i below $D000 leaves all three enables low and ram_addr_o at zero.
- R8: Mode bits take the values on cfg_ram_rd_i, cfg_ram_wr_i and cfg_bank2_i at the first clock edge where cfg_we_i is high. An access in that same cycle uses the old mode. Without cfg_we_i, the mode bits hold.
- R9: When req_valid_i is low, all enables are low.
- R10: ram_addr_o is zero whenever neither ram_re_o nor ram_we_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the mode bits at the next edge |
| cfg_ram_rd_i | input | 1 | New RAM-read bit |
| cfg_ram_wr_i | input | 1 | New RAM-write bit |
| cfg_bank2_i | input | 1 | New Bank-2 bit |
| req_valid_i | input | 1 | An access is presented this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | CPU address |
| rom_re_o | output | 1 | ROM read enable |
| ram_re_o | output | 1 | RAM read enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 16 | Translated RAM address |

## Verification
All four outputs are combinational in the request and the stored mode, so they are due in the same cycle the request is driven. The driver applies each request one time unit after a rising edge, and the monitor compares at the following falling edge. A mode write becomes visible only from the next cycle. The bench model therefore applies a cfg_we_i change only after it has computed the expectation for the request driven in that same cycle. This checks both the old-mode access and the new-mode access that follows it.

// File: rtl/upmap_pkg.sv
package upmap_pkg;
  typedef struct packed {
    logic ram_rd;
    logic ram_wr;
    logic bank2;
  } mode_t;

  localparam mode_t MODE_RESET = '{ram_rd: 1'b0, ram_wr: 1'b0, bank2: 1'b0};
endpackage

// File: rtl/upmap_mode_reg.sv
module upmap_mode_reg
  import upmap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  mode_t mode_i,
  output mode_t mode_o
);
  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= MODE_RESET;
    else if (we_i) mode_q <= mode_i;
  end

  assign mode_o = mode_q;

  p_mode_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mode_o == $past(mode_i));
  p_mode_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mode_o));
endmodule

// File: rtl/upmap_window_dec.sv
module upmap_window_dec #(
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 4,
  parameter int WIN_LO_PAGE = 13,
  parameter int SWAP_PAGE   = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_win_o,
  output logic              swap_pg_o
);
  localparam logic [PAGE_W-1:0] LO_PG = PAGE_W'(WIN_LO_PAGE);
  localparam logic [PAGE_W-1:0] SW_PG = PAGE_W'(SWAP_PAGE);

  logic [PAGE_W-1:0] page;
  assign page      = addr_i[ADDR_W-1 -: PAGE_W];
  assign in_win_o  = page >= LO_PG;
  assign swap_pg_o = page == SW_PG;

  always_comb begin
    a_swap_inside_r6: assert (!swap_pg_o || in_win_o);
  end
endmodule

// File: rtl/upmap_route.sv
module upmap_route
  import upmap_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int ALT_PAGE = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_t             mode_i,
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              in_win_i,
  input  logic              swap_pg_i,
  output logic              rom_re_o,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o
);
  localparam int OFS_W = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] ALT_PG = PAGE_W'(ALT_PAGE);

  logic hit, rd_hit, wr_hit;
  logic [ADDR_W-1:0] mapped;

  assign hit    = valid_i && in_win_i;
  assign rd_hit = hit && !we_i;
  assign wr_hit = hit && we_i;

  // low page of the window is served by the alternate RAM page unless bank 2 is selected
  always_comb begin
    mapped = addr_i;
    if (swap_pg_i && !mode_i.bank2) mapped = {ALT_PG, addr_i[OFS_W-1:0]};
  end

  assign rom_re_o   = rd_hit && !mode_i.ram_rd;
  assign ram_re_o   = rd_hit &&  mode_i.ram_rd;
  assign ram_we_o   = wr_hit &&  mode_i.ram_wr;
  assign ram_addr_o = (ram_re_o || ram_we_o) ? mapped : '0;

  p_no_stray_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !(rom_re_o || ram_re_o || ram_we_o));
  p_low_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win_i |-> !(rom_re_o || ram_re_o || ram_we_o) && ram_addr_o == '0);
  p_low_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_re_o || ram_we_o) |-> ram_addr_o[OFS_W-1:0] == addr_i[OFS_W-1:0]);
endmodule

// File: rtl/upper_mem_mapper.sv
module upper_mem_mapper
  import upmap_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 4,
  parameter int WIN_LO_PAGE = 13,
  parameter int SWAP_PAGE   = 13,
  parameter int ALT_PAGE    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_ram_rd_i,
  input  logic              cfg_ram_wr_i,
  input  logic              cfg_bank2_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rom_re_o,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o
);
  mode_t mode_d, mode_q;
  logic  in_win, swap_pg;

  assign mode_d = '{ram_rd: cfg_ram_rd_i, ram_wr: cfg_ram_wr_i, bank2: cfg_bank2_i};

  upmap_mode_reg i_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .mode_i (mode_d),
    .mode_o (mode_q)
  );

  upmap_window_dec #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_LO_PAGE(WIN_LO_PAGE), .SWAP_PAGE(SWAP_PAGE)
  ) i_dec (
    .addr_i    (req_addr_i),
    .in_win_o  (in_win),
    .swap_pg_o (swap_pg)
  );

  upmap_route #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ALT_PAGE(ALT_PAGE)
  ) i_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .valid_i    (req_valid_i),
    .we_i       (req_we_i),
    .addr_i     (req_addr_i),
    .in_win_i   (in_win),
    .swap_pg_i  (swap_pg),
    .rom_re_o   (rom_re_o),
    .ram_re_o   (ram_re_o),
    .ram_we_o   (ram_we_o),
    .ram_addr_o (ram_addr_o)
  );

  p_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_re_o && (ram_re_o || ram_we_o)));
  p_write_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> mode_q.ram_wr);
  p_read_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |-> mode_q.ram_rd && !req_we_i);
  p_addr_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_re_o || ram_we_o) |-> ram_addr_o == '0);
  p_bank_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ram_re_o || ram_we_o) && swap_pg) |->
      ram_addr_o[ADDR_W-1 -: PAGE_W] == (mode_q.bank2 ? PAGE_W'(SWAP_PAGE) : PAGE_W'(ALT_PAGE)));
endmodule

// File: tb/test_upper_mem_mapper.sv
module test_upper_mem_mapper;
  typedef struct {
    logic        rom;
    logic        rre;
    logic        rwe;
    logic [15:0] addr;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_rd = 0, cfg_wr = 0, cfg_b2 = 0;
  logic valid = 0, we = 0;
  logic [15:0] addr = '0;
  logic rom_re, ram_re, ram_we;
  logic [15:0] ram_addr;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;
  exp_t q[$];
  logic m_rd = 0, m_wr = 0, m_b2 = 0;

  always #2 clk = ~clk;

  upper_mem_mapper i_upper_mem_mapper (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ram_rd_i(cfg_rd),
    .cfg_ram_wr_i(cfg_wr), .cfg_bank2_i(cfg_b2), .req_valid_i(valid),
    .req_we_i(we), .req_addr_i(addr), .rom_re_o(rom_re), .ram_re_o(ram_re),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr)
  );

  function automatic exp_t model(logic v, logic w, logic [15:0] a, string tag);
    exp_t e;
    logic [15:0] mp;
    e.rom = 0; e.rre = 0; e.rwe = 0; e.addr = '0; e.tag = tag;
    mp = (a[15:12] == 4'hD && !m_b2) ? {4'hC, a[11:0]} : a;
    if (v && a >= 16'hD000) begin
      if (w) begin
        if (m_wr) begin e.rwe = 1; e.addr = mp; end
      end else if (m_rd) begin
        e.rre = 1; e.addr = mp;
      end else e.rom = 1;
    end
    return e;
  endfunction

  // one cycle: optional mode write and one request; expectation uses the mode before this edge
  task automatic step(logic cw, logic r, logic w2, logic b, logic v, logic w, logic [15:0] a, string tag);
    @(posedge clk); #1;
    cfg_we = cw; cfg_rd = r; cfg_wr = w2; cfg_b2 = b;
    valid = v; we = w; addr = a;
    q.push_back(model(v, w, a, tag));
    if (cw) begin m_rd = r; m_wr = w2; m_b2 = b; end
  endtask

  task automatic set_mode(logic r, logic w2, logic b);
    step(1, r, w2, b, 0, 0, 16'h0000, "R9");
  endtask

  function automatic string tag_for(logic w, logic [15:0] a);
    if (a < 16'hD000) return "R7";
    if (w && !m_wr) return "R2";
    if (a[15:12] == 4'hD) return "R6";
    if (w) return "R3";
    return (m_rd || !w) ? "R4/R5" : "R5";
  endfunction

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (rom_re !== e.rom || ram_re !== e.rre || ram_we !== e.rwe || ram_addr !== e.addr) begin
          errors++;
          $display("FAIL %s addr=%h: got rom=%b rre=%b rwe=%b ra=%h exp rom=%b rre=%b rwe=%b ra=%h",
                   e.tag, addr, rom_re, ram_re, ram_we, ram_addr, e.rom, e.rre, e.rwe, e.addr);
        end
      end
    end
  end

  initial begin : watchdog
    while (!done && cycles < 20000) begin @(posedge clk); cycles++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] pts[6];
    pts[0] = 16'hCFFF; pts[1] = 16'hD000; pts[2] = 16'hDFFF;
    pts[3] = 16'hE000; pts[4] = 16'hFFFF; pts[5] = 16'hD5A3;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset defaults
    step(0, 0, 0, 0, 1, 0, 16'hE000, "R1");
    step(0, 0, 0, 0, 1, 1, 16'hE000, "R1");
    // R9: no request
    step(0, 0, 0, 0, 0, 0, 16'hE000, "R9");
    step(0, 0, 0, 0, 0, 1, 16'hD000, "R9");
    // all modes over boundary addresses
    for (int m = 0; m < 8; m++) begin
      set_mode(m[2], m[1], m[0]);
      for (int i = 0; i < 6; i++)
        for (int w = 0; w < 2; w++)
          step(0, 0, 0, 0, 1, w[0], pts[i], tag_for(w[0], pts[i]));
    end
    // R8: same-cycle access uses old mode, next cycle new mode
    set_mode(0, 0, 0);
    step(1, 1, 1, 1, 1, 0, 16'hD010, "R8");
    step(0, 0, 0, 0, 1, 0, 16'hD010, "R8");
    step(1, 0, 0, 0, 1, 1, 16'hD020, "R8");
    step(0, 0, 0, 0, 1, 1, 16'hD020, "R8");
    // R4: write enabled, read still from ROM
    set_mode(0, 1, 0);
    step(0, 0, 0, 0, 1, 0, 16'hF123, "R4");
    step(0, 0, 0, 0, 1, 1, 16'hF123, "R3");
    // R1: reset mid-run clears mode
    set_mode(1, 1, 1);
    @(posedge clk); #1 rst_n = 0; valid = 0; cfg_we = 0;
    m_rd = 0; m_wr = 0; m_b2 = 0;
    @(posedge clk); #1 rst_n = 1;
    step(0, 0, 0, 0, 1, 0, 16'hE000, "R1");
    step(0, 0, 0, 0, 1, 1, 16'hD000, "R1");
    @(posedge clk); #1 valid = 0;
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule